// File: doc/BRIEF.md
# Lane Margining Command Responder

This block sits behind the margin-control word of a root-port lane-margining interface and turns each new control word into a margin-status word. A word has three fields: a 3-bit margin type, a 3-bit receiver number and an 8-bit payload. Capability queries are answered in one cycle from capability values driven on input pins. Error-limit writes are answered in one cycle, and vendor-defined and no-command words are echoed in one cycle. Go-to-normal, clear-error-log and the two step commands (timing and voltage) are handed to an external sequencer, and the status is formed when that sequencer reports completion.

A small state machine controls the flow. In state IDLE the block accepts a control word when the valid strobe is high and the word differs from the last word it accepted. Transition IDLE→BUSY is taken when the accepted word needs the sequencer. Transition BUSY→IDLE is taken in the cycle that `seq_done` is sampled high, and the status register is written in that same cycle. Every other accepted word leaves the machine in IDLE and writes the status directly. While the machine is in BUSY, control words are not taken.

Top module: `lmr_responder`

## Requirements
- R1: After reset, the status word is type 111b, receiver 000b, payload 9Ch. In the same state `seq_req` is low and the stored error limit is 0.
- R2: A report command (type 001b) that is accepted writes status type 001b and receiver 001b, with a zero-padded capability field in the payload. The field is chosen by the payload code:
  - 88h: flags in [4:0]
  - 89h: voltage steps in [6:0]
  - 8Ah: timing steps in [5:0]
  - 8Bh: maximum timing offset in [6:0]
  - 8Ch: maximum voltage offset in [6:0]
  - 8Dh: voltage sampling rate in [5:0]
  - 8Eh: timing sampling rate in [5:0]
  - 8Fh: sample count in [6:0]
  - 90h: maximum lane count in [4:0]
- R3: A report, set-limit or step-timing word is ignored (status unchanged) unless its receiver number is in 001b..101b. For step-voltage words the accepted range is 001b..110b. For go-to-normal and clear-error-log words it is 000b..101b.
- R4: An unrecognised word writes the no-command status word (111b/000b/9Ch). This covers a report payload outside 88h..90h, a type 010b payload that is none of the known ones, and types 000b and 110b.
- R5: Type 010b with payload[7:6]=11b stores payload[5:0] as the error limit, which appears on `err_limit`. The status becomes type 001b, receiver 001b, payload {11b, limit}.
- R6: A vendor-defined word (type 101b) writes status type 101b, receiver 001b, and a payload equal to the control payload.
- R7: The no-command word (111b/000b/9Ch) is reflected unchanged in the status.
- R8: Go-to-normal (type 010b, payload 0Fh) and clear-error-log (type 010b, payload 55h) raise `seq_req` one cycle after acceptance, with `seq_op` 00b and 01b respectively. The status is unchanged until `seq_done`. After `seq_done`, the status is type 010b, receiver 001b, and the original payload.
- R9: Step timing (type 011b) and step voltage (type 100b) raise `seq_req` with `seq_op` 10b and 11b respectively, and `seq_arg` carries the control payload. After `seq_done`, the status is the command's type, receiver 001b, and payload `seq_resp`.
- R10: A control word equal to the last accepted word has no effect. A control word that arrives while `seq_req` is high also has no effect.
- R11: `seq_req` stays high until `seq_done` is sampled, and it is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control word valid strobe |
| ctl_type | input | 3 | Control margin type |
| ctl_rcv | input | 3 | Control receiver number |
| ctl_payload | input | 8 | Control payload |
| cap_flags | input | 5 | Capability flags: error sampler, reporting method, left/right timing, up/down voltage, voltage supported |
| cap_volt_steps | input | 7 | Number of voltage steps |
| cap_time_steps | input | 6 | Number of timing steps |
| cap_max_toff | input | 7 | Maximum timing offset |
| cap_max_voff | input | 7 | Maximum voltage offset |
| cap_rate_volt | input | 6 | Voltage sampling rate |
| cap_rate_time | input | 6 | Timing sampling rate |
| cap_samples | input | 7 | Sample count |
| cap_max_lanes | input | 5 | Maximum lane count |
| seq_done | input | 1 | Sequencer has finished the handed-off command |
| seq_resp | input | 8 | Step-command status payload from the sequencer |
| seq_req | output | 1 | Command pending at the sequencer |
| seq_op | output | 2 | Sequencer operation: 00 normal, 01 clear, 10 step timing, 11 step voltage |
| seq_arg | output | 8 | Payload of the handed-off command |
| err_limit | output | 6 | Stored error count limit |
| sts_type | output | 3 | Status margin type |
| sts_rcv | output | 3 | Status receiver number |
| sts_payload | output | 8 | Status payload |

## Verification
A word presented with `ctl_valid` in one cycle is taken at the next rising edge. Direct answers, and `seq_req` for handed-off commands, are therefore visible one cycle after the word is presented. The sequencer-driven status appears one cycle after `seq_done` is presented. The driver stamps each expected status word with the cycle in which it becomes due. The monitor compares it shortly after that edge, and it holds extra expectations across BUSY cycles to show that the status is unchanged while the sequencer works.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
    localparam int TYPE_W = 3;
    localparam int RCV_W  = 3;
    localparam int PL_W   = 8;
    localparam int LIM_W  = 6;
    localparam int OP_W   = 2;

    typedef struct packed {
        logic [TYPE_W-1:0] mtype;
        logic [RCV_W-1:0]  rcv;
        logic [PL_W-1:0]   pl;
    } mword_t;

    localparam logic [TYPE_W-1:0] T_REPORT = 3'b001;
    localparam logic [TYPE_W-1:0] T_SET    = 3'b010;
    localparam logic [TYPE_W-1:0] T_STEP_T = 3'b011;
    localparam logic [TYPE_W-1:0] T_STEP_V = 3'b100;
    localparam logic [TYPE_W-1:0] T_VEND   = 3'b101;

    localparam logic [RCV_W-1:0]  RCV_ONE  = 3'b001;
    localparam mword_t NOCMD_WORD = '{mtype: 3'b111, rcv: 3'b000, pl: 8'h9C};

    typedef enum logic [2:0] {
        K_IGNORE, K_FALLBACK, K_REPORT, K_SETLIM, K_VENDOR, K_SEQ
    } kind_t;

    typedef enum logic [OP_W-1:0] {
        OP_NORMAL = 2'b00, OP_CLEAR = 2'b01, OP_STEP_T = 2'b10, OP_STEP_V = 2'b11
    } seqop_t;

    typedef enum logic {S_IDLE, S_BUSY} state_t;
endpackage

// File: rtl/lmr_report.sv
module lmr_report
    import lmr_pkg::*;
(
    input  logic [PL_W-1:0] code,
    input  logic [4:0]      cap_flags,
    input  logic [6:0]      cap_volt_steps,
    input  logic [5:0]      cap_time_steps,
    input  logic [6:0]      cap_max_toff,
    input  logic [6:0]      cap_max_voff,
    input  logic [5:0]      cap_rate_volt,
    input  logic [5:0]      cap_rate_time,
    input  logic [6:0]      cap_samples,
    input  logic [4:0]      cap_max_lanes,
    output logic [PL_W-1:0] rpt_pl,
    output logic            rpt_hit
);
    always_comb begin
        rpt_hit = 1'b1;
        rpt_pl  = '0;
        case (code)
            8'h88:   rpt_pl = {3'b000, cap_flags};
            8'h89:   rpt_pl = {1'b0, cap_volt_steps};
            8'h8A:   rpt_pl = {2'b00, cap_time_steps};
            8'h8B:   rpt_pl = {1'b0, cap_max_toff};
            8'h8C:   rpt_pl = {1'b0, cap_max_voff};
            8'h8D:   rpt_pl = {2'b00, cap_rate_volt};
            8'h8E:   rpt_pl = {2'b00, cap_rate_time};
            8'h8F:   rpt_pl = {1'b0, cap_samples};
            8'h90:   rpt_pl = {3'b000, cap_max_lanes};
            default: rpt_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lmr_decode.sv
module lmr_decode
    import lmr_pkg::*;
(
    input  mword_t cmd,
    input  logic   rpt_hit,
    output kind_t  kind,
    output seqop_t op
);
    logic rcv_1_5, rcv_0_5, rcv_1_6;

    always_comb begin
        rcv_1_5 = (cmd.rcv >= 3'd1) && (cmd.rcv <= 3'd5);
        rcv_0_5 = (cmd.rcv <= 3'd5);
        rcv_1_6 = (cmd.rcv >= 3'd1) && (cmd.rcv <= 3'd6);
        kind    = K_FALLBACK;
        op      = OP_NORMAL;
        case (cmd.mtype)
            T_REPORT: begin
                if (!rcv_1_5)    kind = K_IGNORE;
                else if (rpt_hit) kind = K_REPORT;
                else             kind = K_FALLBACK;
            end
            T_SET: begin
                if (cmd.pl[7:6] == 2'b11) begin
                    kind = rcv_1_5 ? K_SETLIM : K_IGNORE;
                end else if (cmd.pl == 8'h0F) begin
                    kind = rcv_0_5 ? K_SEQ : K_IGNORE;
                    op   = OP_NORMAL;
                end else if (cmd.pl == 8'h55) begin
                    kind = rcv_0_5 ? K_SEQ : K_IGNORE;
                    op   = OP_CLEAR;
                end
            end
            T_STEP_T: begin
                kind = rcv_1_5 ? K_SEQ : K_IGNORE;
                op   = OP_STEP_T;
            end
            T_STEP_V: begin
                kind = rcv_1_6 ? K_SEQ : K_IGNORE;
                op   = OP_STEP_V;
            end
            T_VEND:  kind = K_VENDOR;
            default: kind = K_FALLBACK;
        endcase
    end
endmodule

// File: rtl/lmr_responder.sv
module lmr_responder
    import lmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_valid,
    input  logic [TYPE_W-1:0] ctl_type,
    input  logic [RCV_W-1:0]  ctl_rcv,
    input  logic [PL_W-1:0]   ctl_payload,
    input  logic [4:0]        cap_flags,
    input  logic [6:0]        cap_volt_steps,
    input  logic [5:0]        cap_time_steps,
    input  logic [6:0]        cap_max_toff,
    input  logic [6:0]        cap_max_voff,
    input  logic [5:0]        cap_rate_volt,
    input  logic [5:0]        cap_rate_time,
    input  logic [6:0]        cap_samples,
    input  logic [4:0]        cap_max_lanes,
    input  logic              seq_done,
    input  logic [PL_W-1:0]   seq_resp,
    output logic              seq_req,
    output logic [OP_W-1:0]   seq_op,
    output logic [PL_W-1:0]   seq_arg,
    output logic [LIM_W-1:0]  err_limit,
    output logic [TYPE_W-1:0] sts_type,
    output logic [RCV_W-1:0]  sts_rcv,
    output logic [PL_W-1:0]   sts_payload
);
    state_t  state_q, state_d;
    mword_t  cmd_in, last_q, sts_q;
    kind_t   kind;
    seqop_t  op_d, op_q;
    logic [PL_W-1:0]   arg_q, rpt_pl;
    logic [TYPE_W-1:0] pend_type_q;
    logic [LIM_W-1:0]  lim_q;
    logic              rpt_hit, accept;

    assign cmd_in = '{mtype: ctl_type, rcv: ctl_rcv, pl: ctl_payload};
    assign accept = ctl_valid && (state_q == S_IDLE) && (cmd_in != last_q);

    lmr_report u_report (
        .code(ctl_payload), .cap_flags(cap_flags), .cap_volt_steps(cap_volt_steps),
        .cap_time_steps(cap_time_steps), .cap_max_toff(cap_max_toff),
        .cap_max_voff(cap_max_voff), .cap_rate_volt(cap_rate_volt),
        .cap_rate_time(cap_rate_time), .cap_samples(cap_samples),
        .cap_max_lanes(cap_max_lanes), .rpt_pl(rpt_pl), .rpt_hit(rpt_hit)
    );

    lmr_decode u_decode (
        .cmd(cmd_in), .rpt_hit(rpt_hit), .kind(kind), .op(op_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept && kind == K_SEQ) state_d = S_BUSY;
            S_BUSY: if (seq_done)                state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q       <= NOCMD_WORD;
            last_q      <= NOCMD_WORD;
            lim_q       <= '0;
            op_q        <= OP_NORMAL;
            arg_q       <= '0;
            pend_type_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        last_q <= cmd_in;
                        unique case (kind)
                            K_REPORT:   sts_q <= '{mtype: T_REPORT, rcv: RCV_ONE, pl: rpt_pl};
                            K_FALLBACK: sts_q <= NOCMD_WORD;
                            K_SETLIM: begin
                                lim_q <= ctl_payload[LIM_W-1:0];
                                sts_q <= '{mtype: T_REPORT, rcv: RCV_ONE,
                                           pl: {2'b11, ctl_payload[LIM_W-1:0]}};
                            end
                            K_VENDOR:   sts_q <= '{mtype: T_VEND, rcv: RCV_ONE, pl: ctl_payload};
                            K_SEQ: begin
                                op_q        <= op_d;
                                arg_q       <= ctl_payload;
                                pend_type_q <= ctl_type;
                            end
                            K_IGNORE:   ;
                            default:    ;
                        endcase
                    end
                end
                S_BUSY: begin
                    if (seq_done) begin
                        if (op_q == OP_NORMAL || op_q == OP_CLEAR)
                            sts_q <= '{mtype: T_SET, rcv: RCV_ONE, pl: arg_q};
                        else
                            sts_q <= '{mtype: pend_type_q, rcv: RCV_ONE, pl: seq_resp};
                    end
                end
                default: ;
            endcase
        end
    end

    assign seq_req     = (state_q == S_BUSY);
    assign seq_op      = op_q;
    assign seq_arg     = arg_q;
    assign err_limit   = lim_q;
    assign sts_type    = sts_q.mtype;
    assign sts_rcv     = sts_q.rcv;
    assign sts_payload = sts_q.pl;
endmodule

// File: rtl/lmr_responder_chk.sv
module lmr_responder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       seq_req,
    input logic       seq_done,
    input logic [2:0] sts_type,
    input logic [2:0] sts_rcv,
    input logic [7:0] sts_payload
);
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> seq_req);

    p_req_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && seq_done) |=> !seq_req);

    p_busy_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && !seq_done) |=> $stable({sts_type, sts_rcv, sts_payload}));

    p_rcv_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_type != 3'b111) |-> (sts_rcv == 3'b001));

    p_nocmd_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_type == 3'b111) |-> (sts_rcv == 3'b000 && sts_payload == 8'h9C));
endmodule

bind lmr_responder lmr_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_done(seq_done),
    .sts_type(sts_type), .sts_rcv(sts_rcv), .sts_payload(sts_payload)
);

// File: tb/lmr_responder_tb.sv
module lmr_responder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_valid = 1'b0;
    logic [2:0] ctl_type = 3'b111;
    logic [2:0] ctl_rcv = 3'b000;
    logic [7:0] ctl_payload = 8'h9C;
    logic       seq_done = 1'b0;
    logic [7:0] seq_resp = 8'h00;
    logic       seq_req;
    logic [1:0] seq_op;
    logic [7:0] seq_arg;
    logic [5:0] err_limit;
    logic [2:0] sts_type, sts_rcv;
    logic [7:0] sts_payload;

    localparam logic [4:0] C_FLAGS = 5'b10110;
    localparam logic [6:0] C_VST = 7'd50, C_TOFF = 7'd40, C_VOFF = 7'd45, C_SMP = 7'd100;
    localparam logic [5:0] C_TST = 6'd31, C_RV = 6'd20, C_RT = 6'd22;
    localparam logic [4:0] C_LANES = 5'd15;
    localparam logic [13:0] NOCMD = {3'b111, 3'b000, 8'h9C};

    always #2.5 clk = ~clk;  // 200 MHz

    lmr_responder u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_valid(ctl_valid), .ctl_type(ctl_type),
        .ctl_rcv(ctl_rcv), .ctl_payload(ctl_payload), .cap_flags(C_FLAGS),
        .cap_volt_steps(C_VST), .cap_time_steps(C_TST), .cap_max_toff(C_TOFF),
        .cap_max_voff(C_VOFF), .cap_rate_volt(C_RV), .cap_rate_time(C_RT),
        .cap_samples(C_SMP), .cap_max_lanes(C_LANES), .seq_done(seq_done),
        .seq_resp(seq_resp), .seq_req(seq_req), .seq_op(seq_op), .seq_arg(seq_arg),
        .err_limit(err_limit), .sts_type(sts_type), .sts_rcv(sts_rcv),
        .sts_payload(sts_payload)
    );

    typedef struct {
        int          due;
        logic [13:0] word;
        logic        req;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare items whose due cycle has arrived
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if ({sts_type, sts_rcv, sts_payload} !== e.word || seq_req !== e.req) begin
                n_fail++;
                $display("FAIL %s: status=%h req=%b expected status=%h req=%b",
                         e.tag, {sts_type, sts_rcv, sts_payload}, seq_req, e.word, e.req);
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one word for one cycle, expect result next edge
    task automatic send(input logic [2:0] t, input logic [2:0] r, input logic [7:0] p,
                        input logic [13:0] exp, input logic req, input string tag);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_type = t; ctl_rcv = r; ctl_payload = p;
        q.push_back('{due: cyc + 1, word: exp, req: req, tag: tag});
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic hold(input logic [13:0] exp, input logic req, input string tag);
        @(negedge clk);
        q.push_back('{due: cyc + 1, word: exp, req: req, tag: tag});
    endtask

    task automatic finish_seq(input logic [7:0] resp, input logic [13:0] exp, input string tag);
        @(negedge clk);
        seq_done = 1'b1; seq_resp = resp;
        q.push_back('{due: cyc + 1, word: exp, req: 1'b0, tag: tag});
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [13:0] busy_sts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({2'b0, sts_type, sts_rcv, sts_payload}, {2'b0, NOCMD}, "R1 status");
        chk({15'b0, seq_req}, 16'h0, "R1 seq_req");
        chk({10'b0, err_limit}, 16'h0, "R1 err_limit");

        // R2: every report code
        send(3'b001, 3'd1, 8'h88, {6'b001001, 3'b000, C_FLAGS}, 0, "R2 88h");
        send(3'b001, 3'd5, 8'h89, {6'b001001, 1'b0, C_VST}, 0, "R2 89h");
        send(3'b001, 3'd2, 8'h8A, {6'b001001, 2'b00, C_TST}, 0, "R2 8Ah");
        send(3'b001, 3'd3, 8'h8B, {6'b001001, 1'b0, C_TOFF}, 0, "R2 8Bh");
        send(3'b001, 3'd4, 8'h8C, {6'b001001, 1'b0, C_VOFF}, 0, "R2 8Ch");
        send(3'b001, 3'd1, 8'h8D, {6'b001001, 2'b00, C_RV}, 0, "R2 8Dh");
        send(3'b001, 3'd1, 8'h8E, {6'b001001, 2'b00, C_RT}, 0, "R2 8Eh");
        send(3'b001, 3'd1, 8'h8F, {6'b001001, 1'b0, C_SMP}, 0, "R2 8Fh");
        send(3'b001, 3'd1, 8'h90, {6'b001001, 3'b000, C_LANES}, 0, "R2 90h");
        // R3: out-of-range receivers leave status untouched
        send(3'b001, 3'd6, 8'h88, {6'b001001, 3'b000, C_LANES}, 0, "R3 report rcv6");
        send(3'b001, 3'd0, 8'h89, {6'b001001, 3'b000, C_LANES}, 0, "R3 report rcv0");
        // R4: unrecognised words
        send(3'b001, 3'd1, 8'h91, NOCMD, 0, "R4 report 91h");
        send(3'b101, 3'd3, 8'hA5, {6'b101001, 8'hA5}, 0, "R6 vendor A5");
        send(3'b000, 3'd1, 8'h12, NOCMD, 0, "R4 type 000");
        send(3'b101, 3'd0, 8'h5A, {6'b101001, 8'h5A}, 0, "R6 vendor 5A");
        send(3'b010, 3'd1, 8'h33, NOCMD, 0, "R4 set unknown");
        send(3'b101, 3'd1, 8'h01, {6'b101001, 8'h01}, 0, "R6 vendor 01");
        // R7: no-command word reflected
        send(3'b111, 3'd0, 8'h9C, NOCMD, 0, "R7 no-command");
        // R5: error limit
        send(3'b010, 3'd2, 8'hEA, {6'b001001, 8'hEA}, 0, "R5 set limit");
        @(negedge clk);
        chk({10'b0, err_limit}, 16'h002A, "R5 err_limit");
        send(3'b010, 3'd0, 8'hC5, {6'b001001, 8'hEA}, 0, "R3 set limit rcv0");
        @(negedge clk);
        chk({10'b0, err_limit}, 16'h002A, "R3 err_limit kept");

        // R8: go-to-normal via sequencer
        busy_sts = {6'b001001, 8'hEA};
        send(3'b010, 3'd0, 8'h0F, busy_sts, 1, "R8 normal req");
        chk({14'b0, seq_op}, 16'h0000, "R8 normal op");
        hold(busy_sts, 1, "R11 req held");
        // R10: word during BUSY ignored
        send(3'b001, 3'd1, 8'h88, busy_sts, 1, "R10 busy word");
        finish_seq(8'hFF, {6'b010001, 8'h0F}, "R8 normal done");
        // R10: same word again has no effect
        send(3'b010, 3'd0, 8'h0F, {6'b010001, 8'h0F}, 0, "R10 repeat word");
        hold({6'b010001, 8'h0F}, 0, "R10 still idle");

        // R8: clear error log
        send(3'b010, 3'd4, 8'h55, {6'b010001, 8'h0F}, 1, "R8 clear req");
        chk({14'b0, seq_op}, 16'h0001, "R8 clear op");
        finish_seq(8'h00, {6'b010001, 8'h55}, "R8 clear done");

        // R9: step timing
        send(3'b011, 3'd1, 8'h05, {6'b010001, 8'h55}, 1, "R9 timing req");
        chk({6'b0, seq_op, seq_arg}, {6'b0, 2'b10, 8'h05}, "R9 timing op/arg");
        hold({6'b010001, 8'h55}, 1, "R11 timing held");
        finish_seq(8'h45, {6'b011001, 8'h45}, "R9 timing done");
        // R3: step timing rcv 6 ignored
        send(3'b011, 3'd6, 8'h07, {6'b011001, 8'h45}, 0, "R3 timing rcv6");
        // R9: step voltage accepts receiver 6
        send(3'b100, 3'd6, 8'h10, {6'b011001, 8'h45}, 1, "R9 voltage req");
        chk({6'b0, seq_op, seq_arg}, {6'b0, 2'b11, 8'h10}, "R9 voltage op/arg");
        finish_seq(8'h83, {6'b100001, 8'h83}, "R9 voltage done");
        send(3'b100, 3'd0, 8'h11, {6'b100001, 8'h83}, 0, "R3 voltage rcv0");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule